// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Access Checks

This block is a small fully associative translation cache. A lookup presents a virtual address, an address-space tag and an access kind. In the same cycle the block reports a hit with the physical address, a miss, or a protection fault. Each stored translation carries its address-space tag. Translations of several processes can therefore coexist, and a context switch needs no invalidation.

After a miss, the surrounding logic finds the translation and writes it in through the fill port. The fill is written at the next clock edge, and later lookups hit. A fill first reuses a slot already holding the same page and tag. Otherwise it takes the lowest empty slot, and when none is empty it takes the slot under a round-robin pointer. Two invalidation commands are provided: one drops every translation, the other drops only the translations of a single address-space tag.

The page size (`PAGE_BITS`), the address widths, the tag width and the slot count (`ENTRIES`) are parameters.

Top module: `tlb_asid`

## Requirements
- R1: The low `PAGE_BITS` bits of the virtual address are the page offset. On a hit, `lk_paddr` is the stored frame number concatenated above that unchanged offset.
- R2: A lookup hits only an occupied slot whose page number and address-space tag both equal the request. The same page under two different tags resolves to two separate translations.
- R3: Access kind is encoded as 0 = read, 1 = write, 2 = execute, and code 3 is treated as a read. A write to a present page whose writable bit is 0 raises `lk_fault` instead of a hit. Reads and writes to a writable page hit.
- R4: An execute access to a present page whose executable bit is 0 raises `lk_fault`. An execute access to an executable page hits.
- R5: A matching slot whose present bit is 0 raises `lk_fault` for every access kind.
- R6: With `lk_req` high, exactly one of `lk_hit`, `lk_miss` and `lk_fault` is high, and `lk_miss` means no slot matched. With `lk_req` low, all three are low. `lk_paddr` is zero unless `lk_hit` is high.
- R7: A fill is visible to a lookup one cycle after the edge that captured it. A fill for a page and tag already held overwrites that same slot.
- R8: A fill that matches no held translation goes to the lowest-numbered empty slot. When every slot is occupied, it goes to the slot under a round-robin pointer. The pointer starts at slot 0 and advances by one for each fill placed through it.
- R9: `flush_all` empties every slot at the next edge.
- R10: `flush_asid_en` empties exactly the slots whose tag equals `flush_asid`, at the next edge. Translations of other tags stay.
- R11: A fill in the same cycle as either flush command is dropped.
- R12: Synchronous reset empties every slot and returns the round-robin pointer to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | VA_W | Virtual address to translate |
| lk_asid | input | ASID_W | Address-space tag of the lookup |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_miss | output | 1 | No matching translation |
| lk_fault | output | 1 | Matching translation denies the access |
| lk_paddr | output | PA_W | Physical address on a hit, zero otherwise |
| fill_en | input | 1 | Write a translation |
| fill_vpn | input | VA_W-PAGE_BITS | Page number of the fill |
| fill_asid | input | ASID_W | Address-space tag of the fill |
| fill_pfn | input | PA_W-PAGE_BITS | Frame number of the fill |
| fill_present | input | 1 | Page is present |
| fill_writable | input | 1 | Page may be written |
| fill_exec | input | 1 | Page may be executed |
| flush_all | input | 1 | Drop every translation |
| flush_asid_en | input | 1 | Drop translations of one tag |
| flush_asid | input | ASID_W | Tag to drop |

## Verification
The bench builds the block with 64 slots, which is the smallest count the design is meant for. It uses 4 KiB pages, 32-bit addresses and an 8-bit tag. With these values the bench can fill every slot by direct stimulus and then push the round-robin pointer past its first two positions. It can also check each eviction against the fill order. The 12-bit offset and 20-bit frame number give distinctive patterns, so a misplaced field in the physical address shows up directly.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef struct packed {
        logic present;
        logic writable;
        logic executable;
    } perm_t;

    // True when the permission set forbids the access kind.
    function automatic logic perm_denies(perm_t p, acc_e a);
        logic deny;
        deny = !p.present;
        if (a == ACC_WRITE && !p.writable)   deny = 1'b1;
        if (a == ACC_EXEC  && !p.executable) deny = 1'b1;
        return deny;
    endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8
) (
    input  logic [ENTRIES-1:0]             slot_valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0]  tag_vpn,
    input  logic [ENTRIES-1:0][ASID_W-1:0] tag_asid,
    input  logic [VPN_W-1:0]               key_vpn,
    input  logic [ASID_W-1:0]              key_asid,
    output logic [ENTRIES-1:0]             match
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = slot_valid[i]
                        && (tag_vpn[i]  == key_vpn)
                        && (tag_asid[i] == key_asid);
    end
endmodule

// File: rtl/tlb_resolve.sv
module tlb_resolve
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PFN_W   = 20
) (
    input  logic                          req,
    input  acc_e                          acc,
    input  logic [ENTRIES-1:0]            match,
    input  perm_t [ENTRIES-1:0]           perms,
    input  logic [ENTRIES-1:0][PFN_W-1:0] pfns,
    output logic                          hit,
    output logic                          miss,
    output logic                          fault,
    output logic [PFN_W-1:0]              pfn
);
    perm_t sel_perm;
    logic  any;

    always_comb begin
        sel_perm = '0;
        pfn      = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                sel_perm = sel_perm | perms[i];
                pfn      = pfn | pfns[i];
            end
        end
        any   = |match;
        miss  = req && !any;
        fault = req && any && perm_denies(sel_perm, acc);
        hit   = req && any && !perm_denies(sel_perm, acc);
    end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] slot_valid,
    input  logic [ENTRIES-1:0] same_tag,
    input  logic               commit,
    output logic [IDX_W-1:0]   victim
);
    logic [IDX_W-1:0] rr_ptr;
    logic [IDX_W-1:0] same_idx;
    logic [IDX_W-1:0] free_idx;
    logic             have_same;
    logic             have_free;
    logic             use_ptr;

    always_comb begin
        same_idx = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (same_tag[i])    same_idx = IDX_W'(i);
            if (!slot_valid[i]) free_idx = IDX_W'(i);
        end
        have_same = |same_tag;
        have_free = !(&slot_valid);
        use_ptr   = !have_same && !have_free;
        if (have_same)      victim = same_idx;
        else if (have_free) victim = free_idx;
        else                victim = rr_ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_ptr <= '0;
        end else if (commit && use_ptr) begin
            rr_ptr <= (rr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/tlb_asid.sv
module tlb_asid
    import tlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ASID_W    = 8,
    parameter int ENTRIES   = 64,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PFN_W    = PA_W - PAGE_BITS,
    localparam int IDX_W    = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_acc,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_fault,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic              fill_present,
    input  logic              fill_writable,
    input  logic              fill_exec,
    input  logic              flush_all,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid
);
    logic [ENTRIES-1:0]             slot_valid;
    logic [ENTRIES-1:0][VPN_W-1:0]  tag_vpn;
    logic [ENTRIES-1:0][ASID_W-1:0] tag_asid;
    logic [ENTRIES-1:0][PFN_W-1:0]  tag_pfn;
    perm_t [ENTRIES-1:0]            tag_perm;

    logic [ENTRIES-1:0] look_match;
    logic [ENTRIES-1:0] fill_match;
    logic [ENTRIES-1:0] asid_kill;
    logic [IDX_W-1:0]   victim;
    logic [PFN_W-1:0]   hit_pfn;
    logic               fill_commit;
    perm_t              fill_perm;

    assign fill_commit = fill_en && !flush_all && !flush_asid_en;
    assign fill_perm   = '{present: fill_present, writable: fill_writable,
                           executable: fill_exec};

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_look_match (
        .slot_valid (slot_valid),
        .tag_vpn    (tag_vpn),
        .tag_asid   (tag_asid),
        .key_vpn    (lk_vaddr[VA_W-1:PAGE_BITS]),
        .key_asid   (lk_asid),
        .match      (look_match)
    );

    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) i_fill_match (
        .slot_valid (slot_valid),
        .tag_vpn    (tag_vpn),
        .tag_asid   (tag_asid),
        .key_vpn    (fill_vpn),
        .key_asid   (fill_asid),
        .match      (fill_match)
    );

    tlb_resolve #(.ENTRIES(ENTRIES), .PFN_W(PFN_W)) i_resolve (
        .req   (lk_req),
        .acc   (acc_e'(lk_acc)),
        .match (look_match),
        .perms (tag_perm),
        .pfns  (tag_pfn),
        .hit   (lk_hit),
        .miss  (lk_miss),
        .fault (lk_fault),
        .pfn   (hit_pfn)
    );

    tlb_victim #(.ENTRIES(ENTRIES)) i_victim (
        .clk        (clk),
        .rst        (rst),
        .slot_valid (slot_valid),
        .same_tag   (fill_match),
        .commit     (fill_commit),
        .victim     (victim)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_kill
        assign asid_kill[i] = (tag_asid[i] == flush_asid);
    end

    assign lk_paddr = lk_hit ? {hit_pfn, lk_vaddr[PAGE_BITS-1:0]} : '0;

    // Occupancy: reset and flushes win over a fill.
    always_ff @(posedge clk) begin
        if (rst || flush_all) begin
            slot_valid <= '0;
        end else if (flush_asid_en) begin
            slot_valid <= slot_valid & ~asid_kill;
        end else if (fill_en) begin
            slot_valid[victim] <= 1'b1;
        end
    end

    // Payload needs no reset; it is qualified by occupancy.
    always_ff @(posedge clk) begin
        if (fill_commit) begin
            tag_vpn[victim]  <= fill_vpn;
            tag_asid[victim] <= fill_asid;
            tag_pfn[victim]  <= fill_pfn;
            tag_perm[victim] <= fill_perm;
        end
    end
endmodule

// File: rtl/tlb_asid_chk.sv
module tlb_asid_chk #(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 64
) (
    input logic               clk,
    input logic               rst,
    input logic               lk_req,
    input logic [VA_W-1:0]    lk_vaddr,
    input logic               lk_hit,
    input logic               lk_miss,
    input logic               lk_fault,
    input logic [PA_W-1:0]    lk_paddr,
    input logic               fill_en,
    input logic               flush_all,
    input logic               flush_asid_en,
    input logic [ENTRIES-1:0] slot_valid,
    input logic [ENTRIES-1:0] look_match
);
    assert_offset_pass_R1: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> lk_paddr[PAGE_BITS-1:0] == lk_vaddr[PAGE_BITS-1:0]);

    assert_single_match_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(look_match));

    assert_one_outcome_R6: assert property (@(posedge clk) disable iff (rst)
        lk_req |-> $countones({lk_hit, lk_miss, lk_fault}) == 1);

    assert_quiet_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !lk_req |-> !(lk_hit || lk_miss || lk_fault));

    assert_paddr_zero_R6: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> lk_paddr == '0);

    assert_fill_occupies_R7: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !flush_all && !flush_asid_en) |=> slot_valid != '0);

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> slot_valid == '0);

    assert_asid_flush_no_new_R11: assert property (@(posedge clk) disable iff (rst)
        (flush_asid_en && !flush_all) |=> (slot_valid & ~$past(slot_valid)) == '0);
endmodule

bind tlb_asid tlb_asid_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .lk_req        (lk_req),
    .lk_vaddr      (lk_vaddr),
    .lk_hit        (lk_hit),
    .lk_miss       (lk_miss),
    .lk_fault      (lk_fault),
    .lk_paddr      (lk_paddr),
    .fill_en       (fill_en),
    .flush_all     (flush_all),
    .flush_asid_en (flush_asid_en),
    .slot_valid    (slot_valid),
    .look_match    (look_match)
);

// File: tb/test_tlb_asid.sv
module test_tlb_asid;
    localparam int VA_W = 32, PA_W = 32, PAGE_BITS = 12, ASID_W = 8, ENTRIES = 64;
    localparam int VPN_W = VA_W - PAGE_BITS, PFN_W = PA_W - PAGE_BITS;

    localparam logic [1:0] OP_LOOK = 2'd0, OP_FILL = 2'd1, OP_FLA = 2'd2, OP_FLS = 2'd3;
    localparam logic [1:0] RS_MISS = 2'd0, RS_HIT = 2'd1, RS_FAULT = 2'd2;
    localparam logic [11:0] OFF = 12'h678;

    typedef struct packed {
        logic [1:0]  op;
        logic [19:0] vpn;
        logic [7:0]  asid;
        logic [1:0]  acc;
        logic [19:0] pfn;
        logic [2:0]  perm;   // present, writable, executable
        logic [1:0]  res;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{OP_LOOK, 20'h12345, 8'd1, 2'd0, 20'h0,     3'b000, RS_MISS,  4'd6},  // R6 empty
        '{OP_FILL, 20'h12345, 8'd1, 2'd0, 20'hABCDE, 3'b110, RS_MISS,  4'd7},
        '{OP_LOOK, 20'h12345, 8'd1, 2'd0, 20'hABCDE, 3'b000, RS_HIT,   4'd1},  // R1 join
        '{OP_LOOK, 20'h12345, 8'd2, 2'd0, 20'h0,     3'b000, RS_MISS,  4'd2},  // R2 tag differs
        '{OP_FILL, 20'h12345, 8'd2, 2'd0, 20'h11111, 3'b101, RS_MISS,  4'd2},
        '{OP_LOOK, 20'h12345, 8'd2, 2'd0, 20'h11111, 3'b000, RS_HIT,   4'd2},
        '{OP_LOOK, 20'h12345, 8'd2, 2'd1, 20'h0,     3'b000, RS_FAULT, 4'd3},  // R3 read-only
        '{OP_LOOK, 20'h12345, 8'd1, 2'd1, 20'hABCDE, 3'b000, RS_HIT,   4'd3},
        '{OP_LOOK, 20'h12345, 8'd1, 2'd2, 20'h0,     3'b000, RS_FAULT, 4'd4},  // R4 no exec
        '{OP_LOOK, 20'h12345, 8'd2, 2'd2, 20'h11111, 3'b000, RS_HIT,   4'd4},
        '{OP_FILL, 20'h00042, 8'd1, 2'd0, 20'h22222, 3'b011, RS_MISS,  4'd5},
        '{OP_LOOK, 20'h00042, 8'd1, 2'd0, 20'h0,     3'b000, RS_FAULT, 4'd5},  // R5 not present
        '{OP_FILL, 20'h12345, 8'd1, 2'd0, 20'h33333, 3'b100, RS_MISS,  4'd7},
        '{OP_LOOK, 20'h12345, 8'd1, 2'd1, 20'h0,     3'b000, RS_FAULT, 4'd7},  // R7 overwrite
        '{OP_LOOK, 20'h12345, 8'd1, 2'd3, 20'h33333, 3'b000, RS_HIT,   4'd7},
        '{OP_FLS,  20'h0,     8'd1, 2'd0, 20'h0,     3'b000, RS_MISS,  4'd10},
        '{OP_LOOK, 20'h12345, 8'd1, 2'd0, 20'h0,     3'b000, RS_MISS,  4'd10}, // R10 dropped
        '{OP_LOOK, 20'h12345, 8'd2, 2'd0, 20'h11111, 3'b000, RS_HIT,   4'd10}, // R10 kept
        '{OP_FLA,  20'h0,     8'd0, 2'd0, 20'h0,     3'b000, RS_MISS,  4'd9},
        '{OP_LOOK, 20'h12345, 8'd2, 2'd0, 20'h0,     3'b000, RS_MISS,  4'd9}   // R9 empty
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lk_req = 1'b0;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic [1:0] lk_acc = '0;
    logic lk_hit, lk_miss, lk_fault;
    logic [PA_W-1:0] lk_paddr;
    logic fill_en = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic fill_present = 1'b0, fill_writable = 1'b0, fill_exec = 1'b0;
    logic flush_all = 1'b0, flush_asid_en = 1'b0;
    logic [ASID_W-1:0] flush_asid = '0;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tlb_asid #(.VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS),
               .ASID_W(ASID_W), .ENTRIES(ENTRIES)) i_tlb_asid (.*);

    task automatic idle_inputs();
        lk_req = 0; fill_en = 0; flush_all = 0; flush_asid_en = 0;
    endtask

    // Drive one lookup after a falling edge, check the combinational result.
    task automatic look(input logic [19:0] vpn, input logic [7:0] asid,
                        input logic [1:0] acc, input logic [1:0] res,
                        input logic [19:0] pfn, input string tag);
        logic [2:0]  exp_f, got_f;
        logic [31:0] exp_pa;
        @(negedge clk);
        idle_inputs();
        lk_req = 1; lk_vaddr = {vpn, OFF}; lk_asid = asid; lk_acc = acc;
        #1;
        exp_f  = {res == RS_HIT, res == RS_MISS, res == RS_FAULT};
        exp_pa = (res == RS_HIT) ? {pfn, OFF} : 32'h0;
        got_f  = {lk_hit, lk_miss, lk_fault};
        n_checks++;
        if (got_f !== exp_f || lk_paddr !== exp_pa) begin
            n_fail++;
            $display("FAIL %s: hit/miss/fault=%b paddr=%h expected %b %h",
                     tag, got_f, lk_paddr, exp_f, exp_pa);
        end
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [7:0] asid,
                        input logic [19:0] pfn, input logic [2:0] perm);
        @(negedge clk);
        idle_inputs();
        fill_en = 1; fill_vpn = vpn; fill_asid = asid; fill_pfn = pfn;
        {fill_present, fill_writable, fill_exec} = perm;
    endtask

    initial begin
        // R12: outputs during and after reset
        repeat (3) @(negedge clk);
        rst = 0;
        look(20'h12345, 8'd1, 2'd0, RS_MISS, 20'h0, "R12 empty after reset");

        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_LOOK: look(VEC[i].vpn, VEC[i].asid, VEC[i].acc, VEC[i].res,
                              VEC[i].pfn, $sformatf("R%0d vector %0d", VEC[i].req, i));
                OP_FILL: fill(VEC[i].vpn, VEC[i].asid, VEC[i].pfn, VEC[i].perm);
                OP_FLA: begin
                    @(negedge clk); idle_inputs(); flush_all = 1;
                end
                default: begin
                    @(negedge clk); idle_inputs();
                    flush_asid_en = 1; flush_asid = VEC[i].asid;
                end
            endcase
        end

        // R6: no request gives no outcome
        @(negedge clk);
        idle_inputs();
        lk_vaddr = {20'h12345, OFF};
        #1;
        n_checks++;
        if ({lk_hit, lk_miss, lk_fault} !== 3'b000 || lk_paddr !== 32'h0) begin
            n_fail++;
            $display("FAIL R6 idle: flags=%b paddr=%h expected 000 0",
                     {lk_hit, lk_miss, lk_fault}, lk_paddr);
        end

        // R11: fill together with a flush is dropped
        fill(20'h00777, 8'd3, 20'h44444, 3'b111);
        flush_all = 1;
        look(20'h00777, 8'd3, 2'd0, RS_MISS, 20'h0, "R11 fill with flush_all");
        fill(20'h00778, 8'd3, 20'h44445, 3'b111);
        flush_asid_en = 1; flush_asid = 8'd9;
        look(20'h00778, 8'd3, 2'd0, RS_MISS, 20'h0, "R11 fill with tag flush");

        // R8: free slots first, then round-robin from slot 0
        for (int i = 0; i < ENTRIES; i++) fill(20'(i), 8'd5, 20'(i + 256), 3'b111);
        look(20'd0, 8'd5, 2'd0, RS_HIT, 20'd256, "R8 all slots held");
        look(20'd63, 8'd5, 2'd2, RS_HIT, 20'd319, "R8 last slot held");
        fill(20'd64, 8'd5, 20'd320, 3'b111);
        look(20'd0, 8'd5, 2'd0, RS_MISS, 20'h0, "R8 slot 0 evicted");
        look(20'd1, 8'd5, 2'd0, RS_HIT, 20'd257, "R8 slot 1 kept");
        look(20'd64, 8'd5, 2'd0, RS_HIT, 20'd320, "R8 new entry");
        fill(20'd65, 8'd5, 20'd321, 3'b111);
        look(20'd1, 8'd5, 2'd0, RS_MISS, 20'h0, "R8 pointer advanced");
        look(20'd2, 8'd5, 2'd0, RS_HIT, 20'd258, "R8 slot 2 kept");

        // R12: reset drops held translations
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        rst = 0;
        look(20'd2, 8'd5, 2'd0, RS_MISS, 20'h0, "R12 reset clears");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule